// File: doc/BRIEF.md
# Configurable Audio Serial Receiver

This block is a clock slave that turns one serial audio data line into parallel left and right sample words. It follows an external bit clock and frame clock, both oversampled by the fast system clock. A synchronizer chain brings both clocks and the data line into the system clock domain. A capture edge is taken from the bit clock, after an optional inversion, and on each such edge the frame clock level and the data bit are sampled together.

The receiver takes the same static settings a matching transmitter would use. These are the framing format (right justified, left justified, I2S or DSP), the word length, bit-clock inversion, frame-clock polarity (which selects mode A or B in DSP format), a time-division mode with a slot select, and a source select for each output that routes either received channel to it. Captured words are left-aligned in 32-bit outputs with zero-filled low bits. One valid pulse marks each completed frame. A bit counter restarts on every frame-clock edge, so the receiver realigns after a short or glitched frame.

Top module: `aud_rx`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `valid_o` is low and both sample outputs are zero.
- R2: Format code 2'b10 (I2S, the value after reset): the left half is the one where the frame clock is low, and the MSB is sampled on the second capture edge of each half.
- R3: Format code 2'b01 (left justified): the left half is the one where the frame clock is high, and the MSB is sampled on the first capture edge of each half.
- R4: Format code 2'b00 (right justified): the left half is high, each word is the last N bits received before the frame-clock transition that ends its half, and the time-division settings have no effect.
- R5: Format code 2'b11 (DSP): a frame begins at the first capture edge where the frame clock is high after being low. With the polarity control at 1 (mode B) the left MSB is on that edge, and with it at 0 (mode A) it is on the next edge. The right word follows directly after the left word.
- R6: Word length code 2'b00/01/10/11 selects N = 16/20/24/32 bits. The word is placed from bit 31 downward and the 32-N low bits read as zero.
- R7: With bit-clock invert at 0, data is captured on rising bit-clock edges. At 1, it is captured on falling edges.
- R8: In the three non-DSP formats, a frame-clock polarity of 1 swaps which frame-clock level marks the left half.
- R9: With time-division enabled in I2S or left-justified format, slot 1 begins N bits after slot 0 within each half. In DSP format, the slot-1 word pair begins 2N bits after slot 0. Only the selected slot is captured.
- R10: The left output carries the received left word when its source select is 0 and the right word when it is 1. The right output follows the same rule with its own select.
- R11: `valid_o` pulses for one cycle per frame once the right word is complete, and only if a left word completed before it. The outputs hold their value between pulses.
- R12: A frame-clock edge that arrives early restarts the bit count. Incomplete words produce no valid pulse, and the next full frame is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | External bit clock |
| lrclk_i | input | 1 | External frame clock |
| sdata_i | input | 1 | Serial data line |
| fmt_i | input | 2 | Framing format code |
| wlen_i | input | 2 | Word length code |
| bclk_inv_i | input | 1 | Capture on falling bit-clock edges when 1 |
| lrc_pol_i | input | 1 | Frame-clock polarity, or DSP mode B when 1 |
| tdm_en_i | input | 1 | Time-division slot mode enable |
| tdm_slot_i | input | 1 | Slot to capture in time-division mode |
| lsrc_i | input | 1 | Left output source: 0 left, 1 right |
| rsrc_i | input | 1 | Right output source: 0 left, 1 right |
| left_o | output | 32 | Left output sample, left-aligned |
| right_o | output | 32 | Right output sample, left-aligned |
| valid_o | output | 1 | One-cycle pulse per completed frame |

## Verification
The assertions take three things for granted about the inputs. Each bit-clock phase lasts longer than the synchronizer chain. The frame clock and data change only around the non-capture bit-clock edge. The static controls change only while reset is held. The stimulus drives each bit as four system cycles in the inactive phase, then four in the active phase, and updates the frame clock and data only at the start of the inactive phase. Every configuration change is applied under reset and followed by a short lead-in at the idle frame-clock level.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    localparam int SMP_W = 32;
    localparam int POS_W = $clog2(SMP_W);

    typedef enum logic [1:0] {
        FMT_RJ  = 2'b00,
        FMT_LJ  = 2'b01,
        FMT_I2S = 2'b10,
        FMT_DSP = 2'b11
    } fmt_e;

    typedef enum logic {
        CH_L = 1'b0,
        CH_R = 1'b1
    } chan_e;

    // Number of bits in one sample for a word-length code.
    function automatic logic [5:0] wl_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 6'd16;
            2'b01:   return 6'd20;
            2'b10:   return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic lrclk_i,
    input  logic sdata_i,
    input  logic bclk_inv_i,
    output logic stb_o,
    output logic lr_o,
    output logic sd_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][2:0] chain;
        logic                   bclk_prev;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     bclk_eff;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = {sdata_i, lrclk_i, bclk_i};
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        bclk_eff       = st_q.chain[LAST][0] ^ bclk_inv_i;
        st_d.bclk_prev = bclk_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain     <= '0;
            st_q.bclk_prev <= 1'b1;   // a capture edge needs a fall first
        end else begin
            st_q <= st_d;
        end
    end

    assign stb_o = bclk_eff & ~st_q.bclk_prev;
    assign lr_o  = st_q.chain[LAST][1];
    assign sd_o  = st_q.chain[LAST][2];

endmodule

// File: rtl/aud_rx_frame.sv
module aud_rx_frame
    import aud_rx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic             lr_i,
    input  logic [1:0]       fmt_i,
    input  logic [1:0]       wlen_i,
    input  logic             lrc_pol_i,
    input  logic             tdm_en_i,
    input  logic             tdm_slot_i,
    output logic             wr_en_o,
    output chan_e            wr_ch_o,
    output logic [POS_W-1:0] wr_pos_o,
    output logic             wr_clr_o,
    output logic             l_fin_o,
    output logic             r_fin_o,
    output logic             rj_bnd_o,
    output chan_e            rj_prev_ch_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lr;
        logic             aligned;
    } frm_st_t;

    frm_st_t          st_d, st_q;
    logic [CNT_W-1:0] wl, k, base, off, start, span, idx, bidx;
    logic             is_dsp, is_rj, restart, al, half_left, in_win, second;

    always_comb begin
        st_d    = st_q;
        wl      = CNT_W'(wl_bits(wlen_i));
        is_dsp  = (fmt_i == FMT_DSP);
        is_rj   = (fmt_i == FMT_RJ);
        restart = is_dsp ? (lr_i & ~st_q.lr) : (lr_i ^ st_q.lr);

        if (restart)        k = '0;
        else if (&st_q.cnt) k = st_q.cnt;
        else                k = st_q.cnt + CNT_W'(1);

        base = ((fmt_i == FMT_I2S) || (is_dsp && !lrc_pol_i)) ? CNT_W'(1) : '0;
        off  = '0;
        if (tdm_en_i && tdm_slot_i && !is_rj) off = is_dsp ? (wl << 1) : wl;
        start = base + off;
        span  = is_dsp ? (wl << 1) : wl;
        al    = st_q.aligned | restart;

        half_left = ((lr_i ^ lrc_pol_i) == (fmt_i != FMT_I2S));
        idx       = k - start;
        in_win    = al && !is_rj && (k >= start) && (idx < span);
        second    = is_dsp ? (idx >= wl) : !half_left;
        bidx      = (is_dsp && second) ? (idx - wl) : idx;

        wr_en_o  = stb_i && in_win;
        wr_ch_o  = second ? CH_R : CH_L;
        wr_pos_o = POS_W'(CNT_W'(SMP_W - 1) - bidx);
        wr_clr_o = (bidx == '0);
        l_fin_o  = wr_en_o && (bidx == wl - CNT_W'(1)) && !second;
        r_fin_o  = wr_en_o && (bidx == wl - CNT_W'(1)) && second;

        rj_bnd_o     = stb_i && is_rj && (lr_i ^ st_q.lr) && st_q.aligned;
        rj_prev_ch_o = (st_q.lr ^ lrc_pol_i) ? CH_L : CH_R;

        if (stb_i) begin
            st_d.cnt     = k;
            st_d.lr      = lr_i;
            st_d.aligned = al;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/aud_rx_assemble.sv
module aud_rx_assemble
    import aud_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic             sd_i,
    input  logic [1:0]       fmt_i,
    input  logic [1:0]       wlen_i,
    input  logic             lsrc_i,
    input  logic             rsrc_i,
    input  logic             wr_en_i,
    input  chan_e            wr_ch_i,
    input  logic [POS_W-1:0] wr_pos_i,
    input  logic             wr_clr_i,
    input  logic             l_fin_i,
    input  logic             r_fin_i,
    input  logic             rj_bnd_i,
    input  chan_e            rj_prev_ch_i,
    output logic [SMP_W-1:0] left_o,
    output logic [SMP_W-1:0] right_o,
    output logic             valid_o
);
    typedef struct packed {
        logic [SMP_W-1:0] lw;
        logic [SMP_W-1:0] rw;
        logic [SMP_W-1:0] sr;
        logic             pend;
        logic [SMP_W-1:0] lo;
        logic [SMP_W-1:0] ro;
        logic             vld;
    } asm_st_t;

    asm_st_t          st_d, st_q;
    logic [SMP_W-1:0] word_rj, cur;
    logic [5:0]       wl6;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        wl6      = wl_bits(wlen_i);
        word_rj  = st_q.sr << (6'd32 - wl6);
        cur      = (wr_ch_i == CH_R) ? st_q.rw : st_q.lw;

        if (stb_i && (fmt_i == FMT_RJ)) st_d.sr = {st_q.sr[SMP_W-2:0], sd_i};

        if (rj_bnd_i) begin
            if (rj_prev_ch_i == CH_L) begin
                st_d.lw   = word_rj;
                st_d.pend = 1'b1;
            end else if (st_q.pend) begin
                st_d.lo   = lsrc_i ? word_rj : st_q.lw;
                st_d.ro   = rsrc_i ? word_rj : st_q.lw;
                st_d.vld  = 1'b1;
                st_d.pend = 1'b0;
            end
        end

        if (wr_en_i) begin
            if (wr_clr_i) cur = '0;
            cur[wr_pos_i] = sd_i;
            if (wr_ch_i == CH_R) st_d.rw = cur;
            else                 st_d.lw = cur;
            if (l_fin_i) st_d.pend = 1'b1;
            if (r_fin_i && st_q.pend) begin
                st_d.lo   = lsrc_i ? cur : st_q.lw;
                st_d.ro   = rsrc_i ? cur : st_q.lw;
                st_d.vld  = 1'b1;
                st_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign left_o  = st_q.lo;
    assign right_o = st_q.ro;
    assign valid_o = st_q.vld;

endmodule

// File: rtl/aud_rx.sv
module aud_rx
    import aud_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bclk_i,
    input  logic        lrclk_i,
    input  logic        sdata_i,
    input  logic [1:0]  fmt_i,
    input  logic [1:0]  wlen_i,
    input  logic        bclk_inv_i,
    input  logic        lrc_pol_i,
    input  logic        tdm_en_i,
    input  logic        tdm_slot_i,
    input  logic        lsrc_i,
    input  logic        rsrc_i,
    output logic [31:0] left_o,
    output logic [31:0] right_o,
    output logic        valid_o
);
    logic             stb, lr, sd;
    logic             wr_en, wr_clr, l_fin, r_fin, rj_bnd;
    chan_e            wr_ch, rj_prev_ch;
    logic [POS_W-1:0] wr_pos;

    aud_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_i     (bclk_i),
        .lrclk_i    (lrclk_i),
        .sdata_i    (sdata_i),
        .bclk_inv_i (bclk_inv_i),
        .stb_o      (stb),
        .lr_o       (lr),
        .sd_o       (sd)
    );

    aud_rx_frame #(.CNT_W(CNT_W)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .stb_i        (stb),
        .lr_i         (lr),
        .fmt_i        (fmt_i),
        .wlen_i       (wlen_i),
        .lrc_pol_i    (lrc_pol_i),
        .tdm_en_i     (tdm_en_i),
        .tdm_slot_i   (tdm_slot_i),
        .wr_en_o      (wr_en),
        .wr_ch_o      (wr_ch),
        .wr_pos_o     (wr_pos),
        .wr_clr_o     (wr_clr),
        .l_fin_o      (l_fin),
        .r_fin_o      (r_fin),
        .rj_bnd_o     (rj_bnd),
        .rj_prev_ch_o (rj_prev_ch)
    );

    aud_rx_assemble u_asm (
        .clk          (clk),
        .rst_n        (rst_n),
        .stb_i        (stb),
        .sd_i         (sd),
        .fmt_i        (fmt_i),
        .wlen_i       (wlen_i),
        .lsrc_i       (lsrc_i),
        .rsrc_i       (rsrc_i),
        .wr_en_i      (wr_en),
        .wr_ch_i      (wr_ch),
        .wr_pos_i     (wr_pos),
        .wr_clr_i     (wr_clr),
        .l_fin_i      (l_fin),
        .r_fin_i      (r_fin),
        .rj_bnd_i     (rj_bnd),
        .rj_prev_ch_i (rj_prev_ch),
        .left_o       (left_o),
        .right_o      (right_o),
        .valid_o      (valid_o)
    );

endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  wlen_i,
    input logic        lsrc_i,
    input logic        rsrc_i,
    input logic [31:0] left_o,
    input logic [31:0] right_o,
    input logic        valid_o
);
    logic [31:0] low_mask;
    assign low_mask = 32'hFFFF_FFFF >> aud_rx_pkg::wl_bits(wlen_i);

    // R1: outputs are clean right after reset release
    p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!valid_o && left_o == '0 && right_o == '0));

    // R11: valid lasts a single cycle
    p_valid_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R11: outputs hold between pulses
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

    // R6: unused low bits are zero
    p_lsb_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (((left_o & low_mask) == '0) && ((right_o & low_mask) == '0)));

    // R10: equal selects give equal outputs
    p_dup_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && lsrc_i == rsrc_i) |-> (left_o == right_o));

endmodule

bind aud_rx aud_rx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wlen_i  (wlen_i),
    .lsrc_i  (lsrc_i),
    .rsrc_i  (rsrc_i),
    .left_o  (left_o),
    .right_o (right_o),
    .valid_o (valid_o)
);

// File: tb/aud_rx_bench.sv
`timescale 1ns/1ps
module aud_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_i = 1'b0, lrclk_i = 1'b0, sdata_i = 1'b0;
    logic [1:0]  fmt = 2'b10, wl = 2'b00;
    logic        binv = 0, lpol = 0, tdm = 0, slot = 0, ls = 0, rs = 1;
    logic [31:0] left_o, right_o;
    logic        valid_o;

    int checks = 0, bad = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];
    localparam int HL = 72;

    always #2 clk = ~clk;

    aud_rx u_aud_rx (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .lrclk_i(lrclk_i), .sdata_i(sdata_i),
        .fmt_i(fmt), .wlen_i(wl), .bclk_inv_i(binv), .lrc_pol_i(lpol),
        .tdm_en_i(tdm), .tdm_slot_i(slot), .lsrc_i(ls), .rsrc_i(rs),
        .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int wbits();
        return (wl == 2'b00) ? 16 : (wl == 2'b01) ? 20 : (wl == 2'b10) ? 24 : 32;
    endfunction

    function automatic logic left_lvl();
        return ((fmt == 2'b10) ? 1'b0 : 1'b1) ^ lpol;
    endfunction

    task automatic drive_bit(input logic lr, input logic d);
        bclk_i = binv; lrclk_i = lr; sdata_i = d;
        repeat (4) @(negedge clk);
        bclk_i = ~binv;
        repeat (4) @(negedge clk);
    endtask

    // Bit for position i of a frame whose halves are h0 and h1 bits long.
    task automatic frame_bit(input int i, input int h0, input int h1,
                             input logic [31:0] L, input logic [31:0] R,
                             output logic lr, output logic d);
        int w = wbits();
        int p, st, ds, j, hl;
        logic [31:0] word;
        d = 1'b1;
        if (fmt == 2'b11) begin
            lr = (i == 0);
            st = (lpol ? 0 : 1) + ((tdm && slot) ? 2*w : 0);
            ds = (lpol ? 0 : 1) + ((tdm && !slot) ? 2*w : 0);
            if (tdm) begin
                p = i - ds;
                if (p >= 0 && p < w) d = ~L[31-p];
                else if (p >= w && p < 2*w) d = ~R[31-(p-w)];
            end
            p = i - st;
            if (p >= 0 && p < w) d = L[31-p];
            else if (p >= w && p < 2*w) d = R[31-(p-w)];
        end else begin
            j    = (i < h0) ? i : i - h0;
            hl   = (i < h0) ? h0 : h1;
            word = (i < h0) ? L : R;
            lr   = (i < h0) ? left_lvl() : ~left_lvl();
            if (fmt == 2'b00) begin
                st = hl - w;
                if (j >= st) d = word[31-(j-st)];
            end else begin
                st = ((fmt == 2'b10) ? 1 : 0) + ((tdm && slot) ? w : 0);
                ds = ((fmt == 2'b10) ? 1 : 0) + ((tdm && !slot) ? w : 0);
                if (tdm && j >= ds && j < ds + w) d = ~word[31-(j-ds)];
                if (j >= st && j < st + w) d = word[31-(j-st)];
            end
        end
    endtask

    task automatic send_frame(input logic [31:0] L, input logic [31:0] R,
                              input int h0, input int h1, input bit expect_it, input string req);
        logic lr, d;
        logic [31:0] m, eL, eR;
        m  = 32'hFFFF_FFFF << (32 - wbits());
        eL = L & m; eR = R & m;
        if (expect_it) begin
            exp_q.push_back({ls ? eR : eL, rs ? eR : eL});
            tag_q.push_back(req);
        end
        for (int i = 0; i < h0 + h1; i++) begin
            frame_bit(i, h0, h1, L, R, lr, d);
            drive_bit(lr, d);
        end
    endtask

    task automatic idle_bits(input int n, input logic lr);
        for (int i = 0; i < n; i++) drive_bit(lr, 1'b0);
    endtask

    task automatic configure(input logic [1:0] f, input logic [1:0] w, input logic bi,
                             input logic lp, input logic te, input logic ts,
                             input logic l_s, input logic r_s);
        rst_n = 1'b0;
        fmt = f; wl = w; binv = bi; lpol = lp; tdm = te; slot = ts; ls = l_s; rs = r_s;
        bclk_i = binv;
        lrclk_i = (f == 2'b11) ? 1'b0 : ~left_lvl();
        repeat (3) @(negedge clk);
        check(!valid_o && left_o == 0 && right_o == 0, "R1 outputs under reset",
              {left_o, right_o}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!valid_o && left_o == 0 && right_o == 0, "R1 outputs after release",
              {left_o, right_o}, 64'h0);
        idle_bits(4, (f == 2'b11) ? 1'b0 : ~left_lvl());
    endtask

    task automatic finish_group(input string req);
        idle_bits(4, (fmt == 2'b11) ? 1'b0 : left_lvl());
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, req, 64'(exp_q.size()), 64'h0);
        exp_q.delete(); tag_q.delete();
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected valid", {left_o, right_o}, 64'h0);
            end else begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({left_o, right_o} == e, t, {left_o, right_o}, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'h0, 64'h1);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        // R2 and R6: I2S with 16-bit words
        configure(2'b10, 2'b00, 0, 0, 0, 0, 0, 1);
        send_frame(32'hA5C3_1234, 32'h5A3C_8765, HL, HL, 1, "R2 i2s w16");
        send_frame(32'h0001_FFFF, 32'hFFFE_0000, HL, HL, 1, "R6 i2s w16 edge bits");
        finish_group("R11 i2s frames all published");

        // R7: falling-edge capture, 24-bit
        configure(2'b10, 2'b10, 1, 0, 0, 0, 0, 1);
        send_frame(32'h8123_45FF, 32'h7EDC_BA01, HL, HL, 1, "R7 bclk inverted");
        finish_group("R11 inverted clock");

        // R3: left justified, 20-bit
        configure(2'b01, 2'b01, 0, 0, 0, 0, 0, 1);
        send_frame(32'hF0F0_F0F0, 32'h1357_9BDF, HL, HL, 1, "R3 lj w20");
        finish_group("R11 lj");

        // R8: left justified with swapped polarity, 32-bit
        configure(2'b01, 2'b11, 0, 1, 0, 0, 0, 1);
        send_frame(32'hDEAD_BEEF, 32'h0BAD_F00D, HL, HL, 1, "R8 lj polarity swap w32");
        finish_group("R11 lj polarity");

        // R4: right justified, time-division settings ignored
        configure(2'b00, 2'b00, 0, 0, 1, 1, 0, 1);
        send_frame(32'hC0DE_0000, 32'h4321_0000, HL, HL, 1, "R4 rj w16 tdm ignored");
        send_frame(32'h1111_0000, 32'hEEEE_0000, HL, HL, 1, "R4 rj second frame");
        finish_group("R11 rj");

        // R4 and R8: right justified, swapped polarity, 24-bit
        configure(2'b00, 2'b10, 0, 1, 0, 0, 0, 1);
        send_frame(32'h9ABC_DE00, 32'h2468_AC00, HL, HL, 1, "R8 rj polarity swap w24");
        finish_group("R11 rj polarity");

        // R5: DSP mode B 16-bit, mode A 32-bit
        configure(2'b11, 2'b00, 0, 1, 0, 0, 0, 1);
        send_frame(32'hBEEF_0000, 32'hCAFE_0000, HL, HL, 1, "R5 dsp mode B");
        finish_group("R11 dsp B");
        configure(2'b11, 2'b11, 0, 0, 0, 0, 0, 1);
        send_frame(32'h8000_0001, 32'h7FFF_FFFE, HL, HL, 1, "R5 dsp mode A w32");
        finish_group("R11 dsp A");

        // R9: time-division slots
        configure(2'b10, 2'b00, 0, 0, 1, 1, 0, 1);
        send_frame(32'h3C3C_0000, 32'hA0A0_0000, HL, HL, 1, "R9 i2s slot1");
        finish_group("R11 i2s slot1");
        configure(2'b01, 2'b10, 0, 0, 1, 0, 0, 1);
        send_frame(32'h1234_5600, 32'h6543_2100, HL, HL, 1, "R9 lj slot0");
        finish_group("R11 lj slot0");
        configure(2'b11, 2'b00, 0, 0, 1, 1, 0, 1);
        send_frame(32'h5555_0000, 32'hAAAA_0000, HL, HL, 1, "R9 dsp slot1");
        finish_group("R11 dsp slot1");

        // R10: source selection
        configure(2'b10, 2'b00, 0, 0, 0, 0, 1, 0);
        send_frame(32'h1111_0000, 32'h2222_0000, HL, HL, 1, "R10 crossed");
        finish_group("R11 crossed");
        configure(2'b10, 2'b00, 0, 0, 0, 0, 0, 0);
        send_frame(32'h3333_0000, 32'h4444_0000, HL, HL, 1, "R10 both left");
        finish_group("R11 both left");
        configure(2'b10, 2'b00, 0, 0, 0, 0, 1, 1);
        send_frame(32'h5555_0000, 32'h6666_0000, HL, HL, 1, "R10 both right");
        finish_group("R11 both right");

        // R12: early frame-clock edges
        configure(2'b10, 2'b00, 0, 0, 0, 0, 0, 1);
        send_frame(32'hFFFF_0000, 32'hFFFF_0000, 10, 10, 0, "R12 short halves");
        send_frame(32'h7777_0000, 32'h8888_0000, HL, HL, 1, "R12 after short halves");
        send_frame(32'h0F0F_0000, 32'hF0F0_0000, HL, 6, 0, "R12 short right");
        send_frame(32'h9999_0000, 32'h6666_0000, HL, HL, 1, "R12 after short right");
        finish_group("R12 no extra valid");
        configure(2'b11, 2'b00, 0, 1, 0, 0, 0, 1);
        send_frame(32'hFFFF_0000, 32'hFFFF_0000, 10, 10, 0, "R12 dsp short frame");
        send_frame(32'h1357_0000, 32'h2468_0000, HL, HL, 1, "R12 dsp after short");
        finish_group("R12 dsp no extra valid");

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule